// File: doc/BRIEF.md
# Strap-Addressed I2C Target Front End

This block is the bus-facing half of an I2C target. A fast system clock oversamples the SCL and SDA pins. Each pin passes through a synchroniser and an edge detector. A condition detector turns the edges into START, STOP, bit-sample and bit-shift events. A byte engine then receives the address byte and compares it with a base of 0x42 plus the value on three strap pins. It acknowledges a match, and it also acknowledges the general call address. After a match it either delivers written bytes to a byte-wide register port or serialises bytes that the register port supplies.

SDA is only ever pulled low. The `sda_pull` output is an open-drain enable, and the pad pulls the line low while it is 1. The block follows a START, a repeated START or a STOP from any state. A read that the controller ends with a not-acknowledge leaves the block quiet until the next START or STOP.

Top module: `i2c_strap_target`

## Requirements
- R1: Until a START has been seen, clocked activity on the bus has no effect: no acknowledge is driven and no write byte is delivered.
- R2: A STOP (SDA rising while SCL is steadily high) returns the block to idle with `sda_pull` low; a new transaction may follow at once.
- R3: The device address is 0x42 plus the unsigned value of `strap[2:0]`, giving 0x42 through 0x49. The address byte carries that 7-bit address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). On a match the block pulls SDA low for the whole ninth clock.
- R4: On an address mismatch the block does not acknowledge. It delivers no bytes and drives nothing until the next START.
- R5: The general call byte 0x00 (address 0, write) is acknowledged whatever the straps are, and the data bytes after it are delivered like any other write bytes. The byte 0x01 (address 0, read) is not acknowledged.
- R6: SDA is sampled on SCL rising. The block changes `sda_pull` only while SCL is low, so the line never moves under a high SCL because of the block.
- R7: In a write, every data byte (bits taken MSB first) is acknowledged. `wr_valid` pulses for exactly one cycle with the byte on `wr_data`.
- R8: In a read, `rd_req` pulses for one cycle at the start of each byte and `rd_data` is taken in that same cycle. The byte is sent MSB first, with `sda_pull` = 1 meaning a 0 bit.
- R9: A not-acknowledge from the controller after a read byte ends transmission. No further `rd_req` pulses occur and SDA stays released.
- R10: A repeated START inside a transaction restarts address reception without going through idle, so a write may turn into a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pin | input | 1 | SCL level from the pad |
| sda_pin | input | 1 | SDA level from the pad |
| strap | input | 3 | Address strap pins, added to base 0x42 |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle pulse: `wr_data` holds a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte, taken in the cycle `rd_req` is high |

## Verification
A wrong bit counter or state shows up at the pins within one byte time. Either the acknowledge lands in the wrong clock, so the controller reads a not-acknowledge where a match was expected, or a read byte comes back shifted by one bit. A missed START or STOP shows up at the next transaction: the block stays silent for a matching address, or it acknowledges where it should be silent. Pull changes are watched against the SCL level on every cycle, so drive timing that slips into the SCL-high window is reported in the cycle it occurs.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_TX,
        ST_TX,
        ST_ACK_RX,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          state;
        logic                is_addr;
        logic                rw;
        logic                mack;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shift;
        logic                pull;
        logic                wr_valid;
    } tgt_regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_level,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o,
    output logic sample_o,
    output logic shift_o
);
    typedef struct packed {
        logic start;
        logic stop;
        logic sample;
        logic shift;
    } cond_t;

    cond_t c_q, c_d;
    logic  scl_steady;

    always_comb begin
        scl_steady = scl_level & ~scl_rise;
        c_d.start  = scl_steady & sda_fall;
        c_d.stop   = scl_steady & sda_rise;
        c_d.sample = scl_rise;
        c_d.shift  = scl_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign start_o  = c_q.start;
    assign stop_o   = c_q.stop;
    assign sample_o = c_q.sample;
    assign shift_o  = c_q.shift;

    // R6: a bit sample and a shift event never arrive together
    assert_sample_shift_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && shift_o));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_strap_pkg::*;
#(
    parameter int          ADDR_W    = 7,
    parameter int          STRAP_W   = 3,
    parameter logic [6:0]  BASE_ADDR = 7'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sample_i,
    input  logic              shift_i,
    input  logic              sda_level,
    input  logic              scl_level,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    tgt_regs_t        r_q, r_d;
    logic [ADDR_W-1:0] own_addr;
    logic              addr_hit;
    logic              gcall_hit;

    always_comb begin
        own_addr  = BASE_ADDR[ADDR_W-1:0] + {{(ADDR_W-STRAP_W){1'b0}}, strap};
        addr_hit  = (r_q.shift[BYTE_W-1:1] == own_addr);
        gcall_hit = (r_q.shift == '0);
    end

    always_comb begin
        r_d          = r_q;
        r_d.wr_valid = 1'b0;
        rd_req       = 1'b0;
        if (start_i) begin
            r_d.state   = ST_RX;
            r_d.is_addr = 1'b1;
            r_d.cnt     = '0;
            r_d.pull    = 1'b0;
        end else if (stop_i) begin
            r_d.state = ST_IDLE;
            r_d.pull  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_RX: begin
                    if (sample_i) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], sda_level};
                        r_d.cnt   = r_q.cnt + 1'b1;
                    end else if (shift_i && r_q.cnt == LAST_BIT) begin
                        if (r_q.is_addr) begin
                            if (addr_hit || gcall_hit) begin
                                r_d.state = ST_ACK_TX;
                                r_d.pull  = 1'b1;
                                r_d.rw    = r_q.shift[0];
                            end else begin
                                r_d.state = ST_IGNORE;
                            end
                        end else begin
                            r_d.state    = ST_ACK_TX;
                            r_d.pull     = 1'b1;
                            r_d.wr_valid = 1'b1;
                        end
                    end
                end
                ST_ACK_TX: begin
                    if (shift_i) begin
                        r_d.cnt     = '0;
                        r_d.is_addr = 1'b0;
                        if (r_q.is_addr && r_q.rw) begin
                            rd_req    = 1'b1;
                            r_d.state = ST_TX;
                            r_d.shift = rd_data;
                            r_d.pull  = ~rd_data[BYTE_W-1];
                        end else begin
                            r_d.state = ST_RX;
                            r_d.pull  = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (sample_i) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (shift_i) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.state = ST_ACK_RX;
                            r_d.pull  = 1'b0;
                        end else begin
                            r_d.shift = {r_q.shift[BYTE_W-2:0], 1'b0};
                            r_d.pull  = ~r_q.shift[BYTE_W-2];
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (sample_i) begin
                        r_d.mack = ~sda_level;
                    end else if (shift_i) begin
                        if (r_q.mack) begin
                            rd_req    = 1'b1;
                            r_d.state = ST_TX;
                            r_d.cnt   = '0;
                            r_d.shift = rd_data;
                            r_d.pull  = ~rd_data[BYTE_W-1];
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    r_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull = r_q.pull;
    assign wr_valid = r_q.wr_valid;
    assign wr_data  = r_q.shift;

    // R6: the pull enable only moves while the synchronised SCL is low
    assert_pull_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_level);

    // R2: a STOP always leaves SDA released
    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_pull);

    // R7: a write byte strobe lasts one cycle
    assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R8: the first bit driven is the MSB of the byte taken with the request
    assert_rd_msb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (sda_pull == !$past(rd_data[BYTE_W-1])));
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
    parameter int         SYNC_STAGES = 3,
    parameter int         ADDR_W      = 7,
    parameter int         STRAP_W     = 3,
    parameter logic [6:0] BASE_ADDR   = 7'h42
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_pin,
    input  logic               sda_pin,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic               wr_valid,
    output logic [7:0]         wr_data,
    output logic               rd_req,
    input  logic [7:0]         rd_data
);
    logic scl_level, scl_rise, scl_fall;
    logic sda_level, sda_rise, sda_fall;
    logic ev_start, ev_stop, ev_sample, ev_shift;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(scl_pin),
        .level_o(scl_level), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(sda_pin),
        .level_o(sda_level), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_level(scl_level), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(ev_start), .stop_o(ev_stop),
        .sample_o(ev_sample), .shift_o(ev_shift)
    );

    i2c_byte_engine #(
        .ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .BASE_ADDR(BASE_ADDR)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_i(ev_start), .stop_i(ev_stop),
        .sample_i(ev_sample), .shift_i(ev_shift),
        .sda_level(sda_level), .scl_level(scl_level),
        .strap(strap), .rd_data(rd_data),
        .sda_pull(sda_pull), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req)
    );
endmodule

// File: tb/i2c_strap_target_tb.sv
module i2c_strap_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;

    typedef struct packed {
        logic [2:0] strap;
        logic [7:0] abyte;
        logic       ack;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h84, 1'b1},
        '{3'd7, 8'h92, 1'b1},
        '{3'd5, 8'h8E, 1'b1},
        '{3'd5, 8'h8C, 1'b0},
        '{3'd3, 8'h8A, 1'b1},
        '{3'd0, 8'h00, 1'b1},
        '{3'd2, 8'h01, 1'b0},
        '{3'd6, 8'h90, 1'b1},
        '{3'd1, 8'h8A, 1'b0},
        '{3'd4, 8'h92, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic       sda_pull, wr_valid, rd_req;
    logic [7:0] wr_data, rd_data;
    logic       sda_bus;

    int  n_chk = 0, n_bad = 0;
    int  wr_cnt = 0, rd_cnt = 0, rd_idx = 0, viol = 0;
    logic [7:0] wr_last = '0;
    logic in_cond = 1'b0, prev_sda = 1'b1, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    function automatic logic [7:0] pat(int i);
        return 8'(32'h5A ^ (i * 37));
    endfunction

    assign rd_data = pat(rd_idx);

    i2c_strap_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_m), .sda_pin(sda_bus),
        .strap(strap), .sda_pull(sda_pull), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
    );

    always @(posedge clk) if (rd_req) begin
        rd_idx <= rd_idx + 1;
        rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) begin
        if (wr_valid) begin
            wr_cnt  = wr_cnt + 1;
            wr_last = wr_data;
        end
        if (rst_n && scl_m && !in_cond && sda_bus !== prev_sda) viol = viol + 1;
        prev_sda = sda_bus;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        in_cond = 1'b1;
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
        in_cond = 1'b0;
    endtask

    task automatic bus_stop();
        in_cond = 1'b1;
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(2*Q);
        in_cond = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; hold(Q);
        scl_m = 1'b1; hold(2*Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic get_bit(output logic v);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        v = sda_bus; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v);
        ack = !v;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(!mack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        int         w0, r0, e_idx;

        hold(5);
        // Reset state (R2): released bus, no strobes
        chk(!sda_pull && !wr_valid && !rd_req, "R2 reset outputs", {sda_pull, wr_valid, rd_req}, 0);
        rst_n = 1'b1;
        hold(5);

        // R1: a matching byte clocked without any START is ignored
        scl_m = 1'b0; hold(Q);
        send_byte(8'h84, ack);
        chk(!ack, "R1 no ack before START", ack, 0);
        chk(wr_cnt == 0, "R1 no write before START", wr_cnt, 0);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(2*Q);

        // Vector table: address matching over straps (R3, R4, R5)
        for (int k = 0; k < NV; k++) begin
            strap = VECS[k].strap;
            hold(Q);
            w0 = wr_cnt;
            bus_start();
            send_byte(VECS[k].abyte, ack);
            chk(ack == VECS[k].ack,
                VECS[k].ack ? "R3 R5 address ack" : "R4 address silent",
                ack, VECS[k].ack);
            chk(wr_cnt == w0, "R7 address byte not delivered", wr_cnt, w0);
            bus_stop();
        end

        // R7: multi-byte write to 0x44
        strap = 3'd2;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h88, ack);
        chk(ack, "R3 write address", ack, 1);
        send_byte(8'h3C, ack);
        chk(ack && wr_last == 8'h3C && wr_cnt == w0 + 1, "R7 first write byte", wr_last, 8'h3C);
        send_byte(8'hA1, ack);
        chk(ack && wr_last == 8'hA1 && wr_cnt == w0 + 2, "R7 second write byte", wr_last, 8'hA1);
        bus_stop();

        // R4: mismatch followed by data stays silent
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h90, ack);
        chk(!ack, "R4 mismatch address", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R4 no ack on data", ack, 0);
        chk(wr_cnt == w0, "R4 no delivery", wr_cnt, w0);
        bus_stop();

        // R5: general call data delivered
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h00, ack);
        chk(ack, "R5 general call ack", ack, 1);
        send_byte(8'h06, ack);
        chk(ack && wr_last == 8'h06 && wr_cnt == w0 + 1, "R5 general call data", wr_last, 8'h06);
        bus_stop();

        // R8 / R9: read three bytes from 0x49, NoAck on the last
        strap = 3'd7;
        r0 = rd_cnt;
        e_idx = rd_idx;
        bus_start();
        send_byte(8'h93, ack);
        chk(ack, "R3 read address", ack, 1);
        for (int j = 0; j < 3; j++) begin
            recv_byte(j < 2, b);
            chk(b == pat(e_idx + j), "R8 read byte", b, pat(e_idx + j));
        end
        chk(rd_cnt == r0 + 3, "R8 request count", rd_cnt, r0 + 3);
        hold(4*Q);
        chk(!sda_pull && rd_cnt == r0 + 3, "R9 NoAck ends read", rd_cnt, r0 + 3);
        bus_stop();
        chk(!sda_pull, "R2 idle after STOP", sda_pull, 0);

        // R2: a new transaction directly after the STOP
        bus_start();
        send_byte(8'h92, ack);
        chk(ack, "R2 ready after STOP", ack, 1);
        bus_stop();

        // R10: write then repeated START into a read at 0x47
        strap = 3'd5;
        e_idx = rd_idx;
        bus_start();
        send_byte(8'h8E, ack);
        send_byte(8'h55, ack);
        chk(ack && wr_last == 8'h55, "R10 write before restart", wr_last, 8'h55);
        bus_start();
        send_byte(8'h8F, ack);
        chk(ack, "R10 restart address ack", ack, 1);
        recv_byte(1'b0, b);
        chk(b == pat(e_idx), "R10 read after restart", b, pat(e_idx));
        bus_stop();

        // R6: the line never moved under a high SCL outside START/STOP
        chk(viol == 0, "R6 SDA stable while SCL high", viol, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule